// File: doc/BRIEF.md
# PCI Dual Address Cycle Decoder

This block sits on a 32-bit PCI-style bus as a passive target-side observer of address phases. Every transaction begins with a falling edge of FRAME#. The block then reports one memory address of up to 44 bits together with the bus command. A plain transaction carries its whole address in one clock. A transaction that opens with the dual-address command code carries two address words: the low word comes on the opening clock, and the high word and the real command come on the next clock. Downstream decode logic receives a single-clock strobe with the assembled address, the command, and a flag that tells a two-word transaction from a one-word one.

Only external initiators may use two-word addressing. A side input marks the current initiator as on-chip, for example an internal bus master or a processor-originated request. If such an initiator opens with the dual-address code, the block emits an error strobe in place of an address and treats the rest of the transaction as data.

The control is a three-state machine. IDLE waits for a new address phase. HIGH takes the high address word. BUSY ignores the bus until the transaction ends. The transitions are: IDLE to HIGH on a start with the dual code from an external initiator; IDLE to BUSY on any other start; HIGH to BUSY always; BUSY to IDLE when FRAME# and IRDY# are both high.

Top module: `pci_dac_decoder`

## Requirements
- R1: When the opening-clock C/BE# is not 4'b1101, the block reports `addr_out = {12'h000, AD}` and `cmd_out` = opening-clock C/BE#, with `dual_out` = 0. `addr_valid` is high in the clock after the one in which the opening word was sampled.
- R2: An opening-clock C/BE# of 4'b1101 from an external initiator (`init_internal` = 0) marks a two-word transaction. The opening-clock AD becomes `addr_out[31:0]`. `addr_valid` and `dual_out` are both high for the clock after the second address word is sampled.
- R3: In a two-word transaction, `addr_out[43:32]` is taken from second-clock AD[11:0]. AD[31:12] of that word have no effect on any output.
- R4: In a two-word transaction, `cmd_out` is the second-clock C/BE#, not the dual code.
- R5: When `init_internal` = 1 on an opening clock that carries 4'b1101, `dac_err` pulses for one clock. No address is reported for that transaction, and the second clock is not taken as an address word.
- R6: A start is only a high-to-low FRAME# transition as seen on two consecutive clocks. A FRAME# that is already low when reset ends is not a start. The block leaves BUSY only when FRAME# and IRDY# are both high. Until then, FRAME# activity and C/BE# values (including 4'b1101) produce no output.
- R7: `addr_valid` and `dac_err` are single-clock pulses and never high together. `dual_out` is only high together with `addr_valid`.
- R8: Reset is synchronous and active low. It clears `addr_valid`, `dual_out` and `dac_err`, and it abandons a two-word transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| cbe_n | input | 4 | C/BE# command / byte enables |
| ad | input | 32 | Multiplexed address/data bus |
| init_internal | input | 1 | Current initiator is on-chip (two-word addressing not allowed) |
| addr_valid | output | 1 | One-clock strobe: address and command are valid |
| addr_out | output | 44 | Assembled memory address |
| cmd_out | output | 4 | Bus command of the transaction |
| dual_out | output | 1 | Address came from a two-word transaction |
| dac_err | output | 1 | One-clock strobe: on-chip initiator used the dual code |

## Verification
The bound checker watches the output contract on every clock:
- the strobes last one clock each and never coincide, and `dual_out` only appears with `addr_valid`;
- the reported command equals C/BE# of the clock before the strobe;
- the upper address bits come from AD[11:0] of the preceding word, and are zero for one-word transactions;
- the low word of a two-word transaction and the dual code match the bus two clocks back;
- every error strobe follows an opening clock from an on-chip initiator that carried the dual code.

Only the bench's scenarios can show the remaining behaviour. These are: a FRAME# held low across reset is not a start; the dual code appearing in data phases and a FRAME# drop before IRDY# releases are both ignored; a reset in the middle of a two-word transaction produces nothing; junk above AD[11] never leaks into the address.

// File: rtl/pci_dac_pkg.sv
package pci_dac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_BUSY = 2'd2
    } dac_state_e;

    localparam logic [3:0] CBE_DUAL_ADDR = 4'b1101;

endpackage

// File: rtl/pci_frame_edge.sv
module pci_frame_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    output logic start
);
    logic frame_hi_q;

    // Reset value 0: a FRAME# already low at reset release is not a start.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_hi_q <= 1'b0;
        else        frame_hi_q <= frame_n;
    end

    assign start = frame_hi_q & ~frame_n;
endmodule

// File: rtl/pci_dac_fsm.sv
module pci_dac_fsm
    import pci_dac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_dual,
    input  logic       internal,
    input  logic       frame_n,
    input  logic       irdy_n,
    output dac_state_e state
);
    dac_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (is_dual && !internal) state_d = ST_HIGH;
                    else                      state_d = ST_BUSY;
                end
            end
            ST_HIGH: state_d = ST_BUSY;
            ST_BUSY: begin
                if (frame_n && irdy_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pci_dac_capture.sv
module pci_dac_capture
    import pci_dac_pkg::*;
#(
    parameter int unsigned AD_W   = 32,
    parameter int unsigned ADDR_W = 44,
    parameter int unsigned CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dac_state_e        state,
    input  logic              start,
    input  logic              is_dual,
    input  logic              internal,
    input  logic [AD_W-1:0]   ad,
    input  logic [CMD_W-1:0]  cbe_n,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CMD_W-1:0]  cmd_out,
    output logic              dual_out,
    output logic              dac_err
);
    localparam int unsigned HI_W = ADDR_W - AD_W;

    logic [AD_W-1:0] low_word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            dual_out   <= 1'b0;
            dac_err    <= 1'b0;
            addr_out   <= '0;
            cmd_out    <= '0;
            low_word_q <= '0;
        end else begin
            addr_valid <= 1'b0;
            dual_out   <= 1'b0;
            dac_err    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (is_dual) begin
                            if (internal) dac_err    <= 1'b1;
                            else          low_word_q <= ad;
                        end else begin
                            addr_valid <= 1'b1;
                            addr_out   <= {{HI_W{1'b0}}, ad};
                            cmd_out    <= cbe_n;
                        end
                    end
                end
                ST_HIGH: begin
                    addr_valid <= 1'b1;
                    dual_out   <= 1'b1;
                    addr_out   <= {ad[HI_W-1:0], low_word_q};
                    cmd_out    <= cbe_n;
                end
                ST_BUSY: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pci_dac_decoder.sv
module pci_dac_decoder
    import pci_dac_pkg::*;
#(
    parameter int unsigned AD_W   = 32,
    parameter int unsigned ADDR_W = 44,
    parameter int unsigned CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [CMD_W-1:0]  cbe_n,
    input  logic [AD_W-1:0]   ad,
    input  logic              init_internal,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CMD_W-1:0]  cmd_out,
    output logic              dual_out,
    output logic              dac_err
);
    logic       start;
    logic       is_dual;
    dac_state_e state;

    assign is_dual = (cbe_n == CBE_DUAL_ADDR);

    pci_frame_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .start   (start)
    );

    pci_dac_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_dual  (is_dual),
        .internal (init_internal),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .state    (state)
    );

    pci_dac_capture #(
        .AD_W   (AD_W),
        .ADDR_W (ADDR_W),
        .CMD_W  (CMD_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .start      (start),
        .is_dual    (is_dual),
        .internal   (init_internal),
        .ad         (ad),
        .cbe_n      (cbe_n),
        .addr_valid (addr_valid),
        .addr_out   (addr_out),
        .cmd_out    (cmd_out),
        .dual_out   (dual_out),
        .dac_err    (dac_err)
    );
endmodule

// File: rtl/pci_dac_decoder_chk.sv
module pci_dac_decoder_chk
    import pci_dac_pkg::*;
#(
    parameter int unsigned AD_W   = 32,
    parameter int unsigned ADDR_W = 44,
    parameter int unsigned CMD_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic [CMD_W-1:0]  cbe_n,
    input logic [AD_W-1:0]   ad,
    input logic              init_internal,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr_out,
    input logic [CMD_W-1:0]  cmd_out,
    input logic              dual_out,
    input logic              dac_err
);
    localparam int unsigned HI_W = ADDR_W - AD_W;

    assert_single_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !dual_out) |-> (addr_out[ADDR_W-1:AD_W] == '0));

    assert_dual_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && dual_out) |->
            (addr_out[AD_W-1:0] == $past(ad, 2)) && ($past(cbe_n, 2) == CBE_DUAL_ADDR));

    assert_high_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && dual_out) |-> (addr_out[ADDR_W-1:AD_W] == $past(ad[HI_W-1:0])));

    assert_cmd_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (cmd_out == $past(cbe_n)));

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_err |-> ($past(init_internal) && ($past(cbe_n) == CBE_DUAL_ADDR) && !$past(frame_n)));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dac_err |=> !dac_err);

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && dac_err));

    assert_dual_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dual_out |-> addr_valid);

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!addr_valid && !dual_out && !dac_err));
endmodule

bind pci_dac_decoder pci_dac_decoder_chk #(
    .AD_W   (AD_W),
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_n       (frame_n),
    .cbe_n         (cbe_n),
    .ad            (ad),
    .init_internal (init_internal),
    .addr_valid    (addr_valid),
    .addr_out      (addr_out),
    .cmd_out       (cmd_out),
    .dual_out      (dual_out),
    .dac_err       (dac_err)
);

// File: tb/test_pci_dac_decoder.sv
module test_pci_dac_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b0;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'b0110;
    logic [31:0] ad = 32'hA5A5_5A5A;
    logic        init_internal = 1'b0;
    logic        addr_valid;
    logic [43:0] addr_out;
    logic [3:0]  cmd_out;
    logic        dual_out;
    logic        dac_err;

    typedef struct {
        logic [43:0] addr;
        logic [3:0]  cmd;
        logic        dual;
        logic        err;
        string       req;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_out = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    pci_dac_decoder i_pci_dac_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_n       (frame_n),
        .irdy_n        (irdy_n),
        .cbe_n         (cbe_n),
        .ad            (ad),
        .init_internal (init_internal),
        .addr_valid    (addr_valid),
        .addr_out      (addr_out),
        .cmd_out       (cmd_out),
        .dual_out      (dual_out),
        .dac_err       (dac_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per output strobe.
    always @(negedge clk) begin
        if (rst_n && (addr_valid || dac_err)) begin
            n_out++;
            if (sb.size() == 0) begin
                check(1'b0, "R6", "unexpected strobe", {62'd0, addr_valid, dac_err}, 64'd0);
            end else begin
                cur = sb.pop_front();
                check(dac_err == cur.err, cur.req, "dac_err", {63'd0, dac_err}, {63'd0, cur.err});
                check(addr_valid == !cur.err, cur.req, "addr_valid", {63'd0, addr_valid}, {63'd0, !cur.err});
                if (!cur.err) begin
                    check(addr_out == cur.addr, cur.req, "addr_out", {20'd0, addr_out}, {20'd0, cur.addr});
                    check(cmd_out == cur.cmd, cur.req, "cmd_out", {60'd0, cmd_out}, {60'd0, cur.cmd});
                    check(dual_out == cur.dual, cur.req, "dual_out", {63'd0, dual_out}, {63'd0, cur.dual});
                end
            end
        end
    end

    task automatic push(input logic [43:0] a, input logic [3:0] c, input logic d,
                        input logic e, input string r);
        exp_t x;
        x.addr = a; x.cmd = c; x.dual = d; x.err = e; x.req = r;
        sb.push_back(x);
    endtask

    // Data phases carry the dual code as byte enables: must be ignored (R6).
    task automatic data_phases(input int nd);
        for (int i = 0; i < nd; i++) begin
            @(negedge clk);
            irdy_n  = 1'b0;
            frame_n = (i == nd - 1);
            cbe_n   = 4'b1101;
            ad      = $urandom;
        end
        @(negedge clk);
        irdy_n = 1'b1; frame_n = 1'b1; cbe_n = 4'hF; ad = '0; init_internal = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_single(input logic [31:0] a, input logic [3:0] c,
                              input logic internal, input int nd);
        push({12'h000, a}, c, 1'b0, 1'b0, "R1");
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = c; ad = a; init_internal = internal;
        data_phases(nd);
    endtask

    task automatic run_dual(input logic [31:0] lo, input logic [31:0] hi,
                            input logic [3:0] c, input logic internal,
                            input string r, input int nd);
        if (internal) push('0, '0, 1'b0, 1'b1, r);
        else          push({hi[11:0], lo}, c, 1'b1, 1'b0, r);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'b1101; ad = lo; init_internal = internal;
        @(negedge clk);
        cbe_n = c; ad = hi;
        data_phases(nd);
    endtask

    initial begin
        // R8: outputs clear in reset; FRAME# held low across reset (R6).
        repeat (3) @(negedge clk);
        check(!addr_valid && !dual_out && !dac_err, "R8", "outputs in reset",
              {61'd0, addr_valid, dual_out, dac_err}, 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        frame_n = 1'b1; cbe_n = 4'hF;
        repeat (2) @(negedge clk);
        check(n_out == 0, "R6", "held-low FRAME# after reset", n_out, 0);

        run_single(32'h1234_5678, 4'b0110, 1'b0, 2);
        run_single(32'hFFFF_FFFF, 4'b0111, 1'b0, 1);
        run_single(32'h0000_0040, 4'b1100, 1'b1, 3);       // internal, no dual code: R1
        run_dual(32'hDEAD_BEEF, 32'h0000_0ABC, 4'b0110, 1'b0, "R2_R4", 2);
        run_dual(32'h0000_1000, 32'hFFFF_F123, 4'b0111, 1'b0, "R3", 1);
        run_dual(32'h8000_0001, 32'h0000_1FFF, 4'b1110, 1'b0, "R3", 1);
        run_dual(32'h1111_2222, 32'h0000_0333, 4'b0110, 1'b1, "R5", 2);
        run_single(32'h0BAD_F00D, 4'b0110, 1'b0, 1);

        // R6: FRAME# dropping again before IRDY# releases is no start.
        n_out = 0;
        push({12'h000, 32'h0000_0100}, 4'b0110, 1'b0, 1'b0, "R6");
        @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'b0110; ad = 32'h0000_0100;
        @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0;
        @(negedge clk); frame_n = 1'b0; irdy_n = 1'b0; cbe_n = 4'b1101; ad = 32'h0000_0200;
        @(negedge clk); frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        repeat (3) @(negedge clk);
        check(n_out == 1, "R6", "strobes for re-dropped FRAME#", n_out, 1);

        // R8: reset in the middle of a two-word transaction.
        n_out = 0;
        @(negedge clk); frame_n = 1'b0; cbe_n = 4'b1101; ad = 32'h5555_0000;
        @(negedge clk); rst_n = 1'b0; cbe_n = 4'b0110; ad = 32'h0000_0777;
        @(negedge clk);
        check(!addr_valid && !dual_out && !dac_err, "R8", "outputs after mid-cycle reset",
              {61'd0, addr_valid, dual_out, dac_err}, 64'd0);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(n_out == 0, "R8", "abandoned transaction strobes", n_out, 0);

        run_dual(32'hCAFE_0000, 32'h0000_0001, 4'b0111, 1'b0, "R2", 1);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "items still expected", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule